// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-facing side of a simple serial port. A 32-bit bus reaches four word registers: control, receive data, transmit data and status. The block holds a transmit queue and a receive queue. It turns their state into one level-sensitive, active-high interrupt line. Status reports the live queue state, the modem lines and a fill count, and it keeps sticky error flags that software clears by writing 1 to them.

The serial shifters sit outside the block. Each one connects through a byte stream. The transmit side offers the head byte with a valid/ready pair and reports whether its shifter is busy. The receive side delivers a byte with a one-cycle valid strobe and a flag for a frame or parity fault. An internal loopback path feeds transmitted bytes straight back into the receive queue.

Top module: `uart_regif`

## Requirements
- R1: Registers are decoded from the byte address in `addr_i`. Control is at 0x0, receive data at 0x4, transmit data at 0x8 and status at 0xC. An access whose address bits 1:0 are not zero is ignored, and a read of it returns 0. Read data appears on `rdata_o` in the cycle after the request. Control reads back only its defined bits: 12 (flow control), 14 (fill-count source), 15 (enable), 18 (RX interrupt enable), 19 (TX interrupt enable) and 20 (loopback). All other control bits read 0. After reset, control reads 0.
- R2: While control bit 15 is 0, `tx_valid_o` stays low and `rx_valid_i` is ignored. Writes to the transmit data register are still queued.
- R3: A read of receive data removes the oldest byte and returns it in bits 7:0, with zeros above. A read while the receive queue is empty returns 0 and leaves the count at 0.
- R4: A write to transmit data queues `wdata_i[7:0]`, and the bytes leave on `tx_data_o` in write order. Each byte is removed when `tx_valid_o` and `tx_ready_i` are both high. While `tx_valid_o` waits for ready, `tx_data_o` holds its value. A write while the queue is full is discarded and sets status bit 3.
- R5: A byte that arrives while the receive queue is full is discarded and sets status bit 2.
- R6: A byte that arrives with `rx_err_i` high is still queued, and it sets status bit 4.
- R7: Status bit 0 becomes set while the receive queue holds data. Status bit 1 becomes set while the transmit queue has a free slot. Writing 1 clears either bit, but the bit sets again if its condition still holds. `irq_o` is high when (bit 0 and control bit 18) or (bit 1 and control bit 19).
- R8: Status bits 2, 3 and 4 stay set until a 1 is written to them. Writing 0 to them has no effect.
- R9: Status bits 16:11 give a fill count. When control bit 14 is 1, they give the transmit queue count; when it is 0, they give the receive queue count.
- R10: Status bit 5 means the receive queue is empty. Bit 6 means the transmit queue is full. Bit 10 means the transmit queue is empty and `tx_busy_i` is low. Bit 17 mirrors `tx_busy_i`.
- R11: With control bit 12 set, `tx_valid_o` is allowed only while `cts_i` is high, and `rts_o` is low while the receive queue is full. With bit 12 clear, `rts_o` is high. Status bit 7 shows `cts_i` and bit 8 shows `rts_o`.
- R12: With control bits 15 and 20 set, queued transmit bytes move one per cycle into the receive queue. During this, `tx_valid_o` stays low and `rx_valid_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| tx_data_o | output | 8 | Head byte offered to the transmitter |
| tx_valid_o | output | 1 | Head byte is offered |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| tx_busy_i | input | 1 | Transmitter shifter is active |
| rx_data_i | input | 8 | Byte from the receiver |
| rx_valid_i | input | 1 | Receive byte strobe |
| rx_err_i | input | 1 | Frame or parity fault on this byte |
| cts_i | input | 1 | Clear-to-send line |
| rts_o | output | 1 | Request-to-send line |
| irq_o | output | 1 | Interrupt, active high, level |

## Verification
The hardest state to reach is a receive queue that is completely full. This is the only state in which an arriving byte becomes an overrun, `rts_o` drops under flow control, and the receive pending bit must survive a drain until software clears it. The bench steps the queue up to capacity one strobe at a time and reads the fill count after every byte. It then sends one extra byte and enables flow control while the queue is still full. After that it drains the queue by reads and checks the data order, the read of an empty queue, and the clear-by-write of the pending and error bits. The transmit queue is swept to full and overfilled in the same way.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned OFS_CTL = 32'h000;
  localparam int unsigned OFS_RXD = 32'h004;
  localparam int unsigned OFS_TXD = 32'h008;
  localparam int unsigned OFS_STA = 32'h00c;

  localparam int unsigned CTL_FLOW = 12;
  localparam int unsigned CTL_SEL  = 14;
  localparam int unsigned CTL_EN   = 15;
  localparam int unsigned CTL_RXIE = 18;
  localparam int unsigned CTL_TXIE = 19;
  localparam int unsigned CTL_LOOP = 20;
  localparam logic [31:0] CTL_MASK = (32'd1 << CTL_FLOW) | (32'd1 << CTL_SEL) |
                                     (32'd1 << CTL_EN) | (32'd1 << CTL_RXIE) |
                                     (32'd1 << CTL_TXIE) | (32'd1 << CTL_LOOP);

  // sticky flag indices, also status bit positions
  localparam int unsigned ST_RXP  = 0;
  localparam int unsigned ST_TXP  = 1;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned ST_TXE  = 3;
  localparam int unsigned ST_RXE  = 4;
  localparam int unsigned ST_RXMT = 5;
  localparam int unsigned ST_TXFL = 6;
  localparam int unsigned ST_CTS  = 7;
  localparam int unsigned ST_RTS  = 8;
  localparam int unsigned ST_TXMT = 10;
  localparam int unsigned ST_LVL  = 11;
  localparam int unsigned ST_BUSY = 17;
  localparam int unsigned LVL_W   = 6;
  localparam int unsigned NFLAG   = 5;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/uart_irq_stat.sv
module uart_irq_stat
  import uart_regif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] w1c_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [1:0]       ie_i,   // {tx, rx}
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flags_q;

  // set wins over clear: level conditions re-arm at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~w1c_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q[ST_TXP:ST_RXP] & ie_i);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned AW       = 12,
  localparam int unsigned TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic          tx_busy_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_err_i,
  input  logic          cts_i,
  output logic          rts_o,
  output logic          irq_o
);
  logic [31:0] ctl_q, rdata_q, sta;
  logic en, loop, flow, sel;
  logic hit_ctl, hit_rxd, hit_txd, hit_sta;
  logic wr_ctl, wr_txd, wr_sta, rd_any, rd_rxd;

  logic [7:0] tx_head, rx_head, rx_in_data;
  logic [TX_CW-1:0] tx_cnt;
  logic [RX_CW-1:0] rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic lb_move, rx_in_valid, rx_in_err;
  logic [NFLAG-1:0] flags, flag_set, flag_clr;
  logic [LVL_W-1:0] lvl;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned ofs);
    logic [31:0] o;
    o = ofs;
    return (a[1:0] == 2'b00) && (a[AW-1:2] == o[AW-1:2]);
  endfunction

  assign hit_ctl = hit(addr_i, OFS_CTL);
  assign hit_rxd = hit(addr_i, OFS_RXD);
  assign hit_txd = hit(addr_i, OFS_TXD);
  assign hit_sta = hit(addr_i, OFS_STA);
  assign wr_ctl  = req_i && we_i && hit_ctl;
  assign wr_txd  = req_i && we_i && hit_txd;
  assign wr_sta  = req_i && we_i && hit_sta;
  assign rd_any  = req_i && !we_i;
  assign rd_rxd  = rd_any && hit_rxd;

  assign en   = ctl_q[CTL_EN];
  assign loop = ctl_q[CTL_LOOP];
  assign flow = ctl_q[CTL_FLOW];
  assign sel  = ctl_q[CTL_SEL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata_i & CTL_MASK;
  end

  // transmit path
  assign tx_valid_o = en && !loop && !tx_empty && (!flow || cts_i);
  assign tx_data_o  = tx_head;
  assign lb_move    = en && loop && !tx_empty;
  assign tx_push    = wr_txd && !tx_full;
  assign tx_pop     = (tx_valid_o && tx_ready_i) || lb_move;

  uart_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push),
    .data_i (wdata_i[7:0]),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .count_o(tx_cnt),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  // receive path, loopback takes the place of the line
  assign rx_in_valid = en && (loop ? lb_move : rx_valid_i);
  assign rx_in_data  = loop ? tx_head : rx_data_i;
  assign rx_in_err   = en && !loop && rx_valid_i && rx_err_i;
  assign rx_push     = rx_in_valid && !rx_full;
  assign rx_pop      = rd_rxd && !rx_empty;
  assign rts_o       = !flow || !rx_full;

  uart_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_in_data),
    .pop_i  (rx_pop),
    .data_o (rx_head),
    .count_o(rx_cnt),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  // sticky and pending flags
  always_comb begin
    flag_set         = '0;
    flag_set[ST_RXP] = !rx_empty;
    flag_set[ST_TXP] = !tx_full;
    flag_set[ST_OVR] = rx_in_valid && rx_full;
    flag_set[ST_TXE] = wr_txd && tx_full;
    flag_set[ST_RXE] = rx_in_err;
    flag_clr         = wr_sta ? wdata_i[NFLAG-1:0] : '0;
  end

  uart_irq_stat u_stat (
    .clk_i, .rst_ni,
    .w1c_i  (flag_clr),
    .set_i  (flag_set),
    .ie_i   ({ctl_q[CTL_TXIE], ctl_q[CTL_RXIE]}),
    .flags_o(flags),
    .irq_o  (irq_o)
  );

  assign lvl = sel ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    sta                         = '0;
    sta[NFLAG-1:0]              = flags;
    sta[ST_RXMT]                = rx_empty;
    sta[ST_TXFL]                = tx_full;
    sta[ST_CTS]                 = cts_i;
    sta[ST_RTS]                 = rts_o;
    sta[ST_TXMT]                = tx_empty && !tx_busy_i;
    sta[ST_LVL+LVL_W-1:ST_LVL]  = lvl;
    sta[ST_BUSY]                = tx_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_any) begin
      unique case (1'b1)
        hit_ctl: rdata_q <= ctl_q;
        hit_rxd: rdata_q <= rx_empty ? 32'd0 : {24'd0, rx_head};
        hit_sta: rdata_q <= sta;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned AW       = 12,
  parameter int unsigned TX_CW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [31:0]      rdata_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             rx_valid_i,
  input logic             cts_i,
  input logic             irq_o,
  input logic [31:0]      ctl_q,
  input logic [NFLAG-1:0] flags,
  input logic             tx_full,
  input logic             rx_full,
  input logic             rx_empty,
  input logic [TX_CW-1:0] tx_cnt
);
  logic a_txd, a_rxd;
  assign a_txd = (addr_i == AW'(OFS_TXD));
  assign a_rxd = (addr_i == AW'(OFS_RXD));

  // R4
  tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && a_txd && tx_full) |=> flags[ST_TXE]);

  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(tx_data_o));

  // R4
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TX_CW'(TX_DEPTH));

  // R5
  rx_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[CTL_EN] && !ctl_q[CTL_LOOP] && rx_valid_i && rx_full) |=> flags[ST_OVR]);

  // R2
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (ctl_q[CTL_EN] && !ctl_q[CTL_LOOP]));

  // R11
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[CTL_FLOW] && !cts_i) |-> !tx_valid_o);

  // R3
  rx_empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && a_rxd && rx_empty) |=> (rdata_o == 32'd0));

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[CTL_RXIE] && !ctl_q[CTL_TXIE]) |-> !irq_o);
endmodule

bind uart_regif uart_regif_chk #(.TX_DEPTH(TX_DEPTH), .AW(AW), .TX_CW(TX_CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .tx_data_o (tx_data_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .rx_valid_i(rx_valid_i),
  .cts_i     (cts_i),
  .irq_o     (irq_o),
  .ctl_q     (ctl_q),
  .flags     (flags),
  .tx_full   (tx_full),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .tx_cnt    (tx_cnt)
);

// File: tb/tb_uart_regif.sv
`timescale 1ns/1ps
module tb_uart_regif;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 12;
  localparam logic [AW-1:0] A_CTL = 12'h000, A_RXD = 12'h004, A_TXD = 12'h008, A_STA = 12'h00c;
  localparam logic [31:0] C_FLOW = 32'd1 << 12, C_SEL = 32'd1 << 14, C_EN = 32'd1 << 15,
                          C_RXIE = 32'd1 << 18, C_TXIE = 32'd1 << 19, C_LOOP = 32'd1 << 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, we_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [7:0] tx_data_o, rx_data_i = '0;
  logic tx_valid_o, tx_ready_i = 0, tx_busy_i = 0;
  logic rx_valid_i = 0, rx_err_i = 0, cts_i = 0, rts_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regif #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_busy_i,
    .rx_data_i, .rx_valid_i, .rx_err_i, .cts_i, .rts_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic e);
    rx_valid_i = 1; rx_data_i = b; rx_err_i = e;
    @(negedge clk);
    rx_valid_i = 0; rx_err_i = 0;
  endtask

  task automatic tx_take();
    tx_ready_i = 1;
    @(negedge clk);
    tx_ready_i = 0;
  endtask

  function automatic logic [31:0] bitof(input logic [31:0] w, input int p);
    return (w >> p) & 32'd1;
  endfunction

  function automatic logic [31:0] lvl(input logic [31:0] w);
    return (w >> 11) & 32'h3f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // reset state
    check("R7 irq after reset", irq_o, 0);
    bus_rd(A_STA, d);
    check("R10 status after reset", d, 32'h522);
    bus_rd(A_CTL, d);
    check("R1 control after reset", d, 0);

    // R1 readback mask
    bus_wr(A_CTL, 32'hffff_ffff);
    bus_rd(A_CTL, d);
    check("R1 control mask", d, C_FLOW | C_SEL | C_EN | C_RXIE | C_TXIE | C_LOOP);
    check("R7 irq with tx pending", irq_o, 1);
    bus_wr(A_CTL, 0);
    check("R7 irq masked", irq_o, 0);
    bus_rd(A_STA + 12'h1, d);
    check("R1 misaligned read", d, 0);

    // R2 disabled
    rx_byte(8'h11, 0);
    bus_rd(A_STA, d);
    check("R2 rx ignored empty", bitof(d, 5), 1);
    check("R2 rx ignored count", lvl(d), 0);
    bus_wr(A_TXD, 32'h42);
    repeat (3) @(negedge clk);
    check("R2 tx held while disabled", tx_valid_o, 0);
    bus_wr(A_CTL, C_EN | C_SEL);
    bus_rd(A_STA, d);
    check("R9 tx count 1", lvl(d), 1);
    check("R4 tx valid", tx_valid_o, 1);
    check("R4 tx data", tx_data_o, 8'h42);
    tx_take();

    // R4 / R9 fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      bus_wr(A_TXD, (i * 13 + 5) & 8'hff);
      bus_rd(A_STA, d);
      check("R9 tx fill level", lvl(d), i + 1);
    end
    check("R10 tx full flag", bitof(d, 6), 1);
    bus_wr(A_TXD, 32'hee);
    bus_rd(A_STA, d);
    check("R4 overfill error", bitof(d, 3), 1);
    check("R4 overfill count", lvl(d), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R4 tx order valid", tx_valid_o, 1);
      check("R4 tx order data", tx_data_o, (i * 13 + 5) & 8'hff);
      tx_take();
    end
    check("R4 tx drained", tx_valid_o, 0);

    // R8 sticky
    bus_wr(A_STA, 0);
    bus_rd(A_STA, d);
    check("R8 zero write keeps", bitof(d, 3), 1);
    bus_wr(A_STA, 32'h8);
    bus_rd(A_STA, d);
    check("R8 w1c clears", bitof(d, 3), 0);

    // R10 busy
    check("R10 tx all empty", bitof(d, 10), 1);
    tx_busy_i = 1;
    @(negedge clk);
    bus_rd(A_STA, d);
    check("R10 busy bit", bitof(d, 17), 1);
    check("R10 empty while busy", bitof(d, 10), 0);
    tx_busy_i = 0;

    // R3 R5 R6 receive fill
    bus_wr(A_CTL, C_EN);
    for (int i = 0; i < DEPTH; i++) begin
      rx_byte((i * 7 + 3) & 8'hff, i == 5);
      bus_rd(A_STA, d);
      check("R9 rx fill level", lvl(d), i + 1);
    end
    check("R6 rx error flag", bitof(d, 4), 1);
    check("R5 no overrun yet", bitof(d, 2), 0);
    rx_byte(8'h99, 0);
    bus_rd(A_STA, d);
    check("R5 overrun flag", bitof(d, 2), 1);
    check("R5 count held", lvl(d), DEPTH);

    bus_wr(A_CTL, C_EN | C_FLOW);
    check("R11 rts low when full", rts_o, 0);
    bus_rd(A_STA, d);
    check("R11 rts status", bitof(d, 8), 0);

    bus_wr(A_CTL, C_EN | C_RXIE);
    check("R7 rx irq", irq_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(A_RXD, d);
      check("R3 rx data", d, (i * 7 + 3) & 8'hff);
    end
    bus_rd(A_RXD, d);
    check("R3 empty read", d, 0);
    bus_rd(A_STA, d);
    check("R3 count after empty read", lvl(d), 0);
    check("R10 rx empty flag", bitof(d, 5), 1);
    check("R7 rx pending kept", bitof(d, 0), 1);
    bus_wr(A_STA, 32'h1f);
    bus_rd(A_STA, d);
    check("R7 flags after clear", d & 32'h1f, 32'h2);
    check("R7 irq after clear", irq_o, 0);
    bus_wr(A_CTL, C_EN | C_TXIE);
    check("R7 tx irq", irq_o, 1);

    // R11 clear-to-send gating
    bus_wr(A_CTL, C_EN | C_FLOW);
    cts_i = 0;
    bus_wr(A_TXD, 32'h77);
    repeat (2) @(negedge clk);
    check("R11 cts low blocks", tx_valid_o, 0);
    bus_rd(A_STA, d);
    check("R11 cts status low", bitof(d, 7), 0);
    cts_i = 1;
    @(negedge clk);
    check("R11 cts high valid", tx_valid_o, 1);
    check("R11 cts high data", tx_data_o, 8'h77);
    bus_rd(A_STA, d);
    check("R11 cts status high", bitof(d, 7), 1);
    check("R11 rts high", rts_o, 1);
    tx_take();

    // R12 loopback
    bus_wr(A_CTL, C_EN | C_LOOP);
    rx_byte(8'h55, 0);
    bus_wr(A_TXD, 32'ha5);
    bus_wr(A_TXD, 32'h5a);
    check("R12 tx line quiet", tx_valid_o, 0);
    repeat (3) @(negedge clk);
    bus_rd(A_STA, d);
    check("R12 looped count", lvl(d), 2);
    bus_rd(A_RXD, d);
    check("R12 first looped", d, 32'ha5);
    bus_rd(A_RXD, d);
    check("R12 second looped", d, 32'h5a);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule